// File: doc/BRIEF.md
# Game controller button shift register

This block captures the levels of eight button lines into a register and hands them out one bit at a time on a slow shift clock driven from outside. It runs on a fast system clock. The load-control, shift-clock, clock-enable, serial-in and button pins are all treated as asynchronous. Each passes through a two-stage synchronizer. A rising edge of the shift clock is found by comparing the synchronized level with its value one cycle earlier.

A mode parameter picks one of two pin conventions. In the default convention the load control is active high and the three highest register bits are driven out. In the alternate convention the load control is active low, and the shift clock is ORed with an active-low enable so that either pin can serve as the clock. Only the top bit is driven out, together with its complement. In both modes the load is level-sensitive: while it is active the register tracks the buttons, and any shift request is dropped.

Top module: `pad_shift_reg`

## Requirements
- R1: After synchronous reset the register holds all zeros. `taps` reads 3'b000. `top_n` reads 0 in the default mode and 1 in the alternate mode.
- R2: While load is active (default mode: `load_pin` high), every register bit follows its `par_in` bit continuously, so a change of `par_in` during the load also appears at the outputs.
- R3: While load is inactive, a rising edge of the shift clock moves register bit i to bit i+1. Bit 0 takes `ser_in` and the old bit 7 is dropped.
- R4: Shift-clock edges arriving while load is active are ignored. If a load and a shift edge reach the register in the same system cycle, the load wins.
- R5: In the default mode `taps[2]`, `taps[1]` and `taps[0]` show register bits 7, 6 and 5 (positions 8, 7 and 6), and `top_n` is 0. `clk_en_n` has no effect.
- R6: In the alternate mode the load is active while `load_pin` is low, and inactive while it is high.
- R7: In the alternate mode the shift clock is `shift_clk OR clk_en_n`. A rising edge of either pin, while the other is low, causes one shift.
- R8: In the alternate mode `taps[2]` shows register bit 7, `taps[1:0]` read 0, and `top_n` is the complement of bit 7.
- R9: A pin change reaches the outputs on the third rising system-clock edge after it: two synchronizer stages plus the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | 8 | Button levels; bit n loads register bit n |
| ser_in | input | 1 | Value shifted into bit 0 |
| load_pin | input | 1 | Load control; polarity depends on mode |
| shift_clk | input | 1 | External shift clock |
| clk_en_n | input | 1 | Active-low clock enable, ORed with `shift_clk` in the alternate mode |
| taps | output | 3 | Upper register bits (mode dependent) |
| top_n | output | 1 | Complement of bit 7 in the alternate mode, else 0 |

## Verification
The bench drives two instances, one per mode, with the same stimulus.

- **Loads.** Random loads check capture of arbitrary button patterns. A `par_in` change held under load tells a transparent load apart from an edge-captured one.
- **Shifts.** Full eight-shift readouts with random serial data confirm both the shift direction and the serial fill.
- **Enable pulses.** Pulses on `clk_en_n` with `shift_clk` low must shift only the alternate instance. This separates the ORed clock from the plain one.
- **Collisions and latency.** A load raised in the same cycle as a shift edge shows load priority. A cycle-counted shift pins the pipeline depth.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic {
        MODE_HI_LOAD = 1'b0,
        MODE_LO_LOAD = 1'b1
    } psr_mode_e;

    typedef struct packed {
        logic load;
        logic sclk;
        logic en_n;
        logic ser;
    } psr_ctl_t;

    localparam int CTL_BITS = $bits(psr_ctl_t);

    function automatic logic load_active(psr_mode_e mode, logic lvl);
        return (mode == MODE_HI_LOAD) ? lvl : ~lvl;
    endfunction

    function automatic logic shift_level(psr_mode_e mode, logic sclk, logic en_n);
        return (mode == MODE_HI_LOAD) ? sclk : (sclk | en_n);
    endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == $past(stg[STAGES-2])) else $error("sync delay"); // R9
endmodule

// File: rtl/psr_ctl.sv
module psr_ctl
    import psr_pkg::*;
#(
    parameter psr_mode_e MODE = MODE_HI_LOAD
) (
    input  logic     clk,
    input  logic     rst,
    input  psr_ctl_t ctl_s,
    output logic     load_act,
    output logic     shift_req
);
    logic lvl_now;
    logic lvl_prev;

    assign lvl_now  = shift_level(MODE, ctl_s.sclk, ctl_s.en_n);
    assign load_act = load_active(MODE, ctl_s.load);

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= 1'b0;
        else     lvl_prev <= lvl_now;
    end

    assign shift_req = lvl_now & ~lvl_prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        shift_req |=> !shift_req) else $error("edge pulse too long"); // R7
    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        shift_req |=> lvl_prev) else $error("edge without level"); // R3
endmodule

// File: rtl/psr_core.sv
module psr_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_act,
    input  logic         shift_req,
    input  logic [W-1:0] par,
    input  logic         ser,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (load_act)  q <= par;
        else if (shift_req) q <= {q[W-2:0], ser};
    end

    AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (rst)
        load_act |=> q == $past(par)) else $error("load not tracked"); // R2
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
        (shift_req && !load_act) |=> q == {$past(q[W-2:0]), $past(ser)}) else $error("bad shift"); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift_req && !load_act) |=> $stable(q)) else $error("idle change"); // R4
endmodule

// File: rtl/pad_shift_reg.sv
module pad_shift_reg
    import psr_pkg::*;
#(
    parameter int        WIDTH    = 8,
    parameter int        NUM_TAPS = 3,
    parameter int        STAGES   = 2,
    parameter psr_mode_e MODE     = MODE_HI_LOAD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WIDTH-1:0]    par_in,
    input  logic                ser_in,
    input  logic                load_pin,
    input  logic                shift_clk,
    input  logic                clk_en_n,
    output logic [NUM_TAPS-1:0] taps,
    output logic                top_n
);
    localparam int BUS_W = WIDTH + CTL_BITS;

    psr_ctl_t         ctl_raw;
    psr_ctl_t         ctl_s;
    logic [WIDTH-1:0] par_s;
    logic             load_act;
    logic             shift_req;
    logic [WIDTH-1:0] q;

    assign ctl_raw = '{load: load_pin, sclk: shift_clk, en_n: clk_en_n, ser: ser_in};

    psr_sync #(.W(BUS_W), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({par_in, ctl_raw}),
        .q   ({par_s, ctl_s})
    );

    psr_ctl #(.MODE(MODE)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_s     (ctl_s),
        .load_act  (load_act),
        .shift_req (shift_req)
    );

    psr_core #(.W(WIDTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load_act  (load_act),
        .shift_req (shift_req),
        .par       (par_s),
        .ser       (ctl_s.ser),
        .q         (q)
    );

    generate
        if (MODE == MODE_HI_LOAD) begin : g_hi
            assign taps  = q[WIDTH-1 -: NUM_TAPS];
            assign top_n = 1'b0;
        end else begin : g_lo
            assign taps  = {q[WIDTH-1], {(NUM_TAPS-1){1'b0}}};
            assign top_n = ~q[WIDTH-1];
        end
    endgenerate

    AST_TOP_COMPL: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_LO_LOAD) |-> top_n != taps[NUM_TAPS-1]) else $error("complement"); // R8
    AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (rst)
        load_act |=> taps == $past(par_s[WIDTH-1 -: NUM_TAPS]) || MODE == MODE_LO_LOAD) else $error("load lost"); // R4
endmodule

// File: tb/pad_shift_reg_bench.sv
module pad_shift_reg_bench;
    import psr_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] par_in = '0;
    logic       ser_in = 1'b0;
    logic       load_hi = 1'b0;
    logic       shift_clk = 1'b0;
    logic       clk_en_n = 1'b0;
    logic [2:0] taps_d, taps_a;
    logic       topn_d, topn_a;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_def = '0;
    logic [7:0] m_alt = '0;

    always #5 clk = ~clk;

    pad_shift_reg #(.MODE(MODE_HI_LOAD)) u_pad_shift_reg (
        .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in),
        .load_pin(load_hi), .shift_clk(shift_clk), .clk_en_n(clk_en_n),
        .taps(taps_d), .top_n(topn_d)
    );

    pad_shift_reg #(.MODE(MODE_LO_LOAD)) u_pad_shift_reg_alt (
        .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in),
        .load_pin(~load_hi), .shift_clk(shift_clk), .clk_en_n(clk_en_n),
        .taps(taps_a), .top_n(topn_a)
    );

    function automatic logic [7:0] shifted(logic [7:0] v, logic s);
        return {v[6:0], s};
    endfunction

    function automatic logic [3:0] exp_def(logic [7:0] v);
        return {v[7:5], 1'b0};
    endfunction

    function automatic logic [3:0] exp_alt(logic [7:0] v);
        return {v[7], 2'b00, ~v[7]};
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_both(string tag_d, string tag_a);
        check(tag_d, {taps_d, topn_d}, exp_def(m_def));
        check(tag_a, {taps_a, topn_a}, exp_alt(m_alt));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(logic [7:0] v);
        load_hi = 1'b1; par_in = v; settle();
        m_def = v; m_alt = v;
        check_both("R2 load default", "R6 load alt");
        load_hi = 1'b0; settle();
    endtask

    task automatic do_shift(logic s);
        ser_in = s; settle();
        shift_clk = 1'b1; settle();
        m_def = shifted(m_def, s); m_alt = shifted(m_alt, s);
        check_both("R3 R5 shift default", "R3 R8 shift alt");
        shift_clk = 1'b0; settle();
    endtask

    task automatic do_enable_pulse(logic s);
        ser_in = s; settle();
        clk_en_n = 1'b1; settle();
        m_alt = shifted(m_alt, s);
        check_both("R5 enable ignored default", "R7 enable clocks alt");
        clk_en_n = 1'b0; settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_both("R1 reset default", "R1 reset alt");
        settle();
        check_both("R1 idle default", "R1 idle alt");

        // R2 transparency while load held
        load_hi = 1'b1; par_in = 8'hA5; settle();
        m_def = 8'hA5; m_alt = 8'hA5;
        check_both("R2 hold first", "R6 hold first");
        par_in = 8'h5A; settle();
        m_def = 8'h5A; m_alt = 8'h5A;
        check_both("R2 hold changed", "R6 hold changed");

        // R4 shift during load ignored
        shift_clk = 1'b1; settle();
        check_both("R4 shift under load default", "R4 shift under load alt");
        shift_clk = 1'b0; settle();
        load_hi = 1'b0; settle();
        check_both("R4 after release default", "R4 after release alt");

        // R9 latency
        do_load(8'h40);
        shift_clk = 1'b1;
        repeat (2) @(negedge clk);
        check_both("R9 early default", "R9 early alt");
        @(negedge clk);
        m_def = shifted(m_def, 1'b0); m_alt = shifted(m_alt, 1'b0);
        check_both("R9 on time default", "R9 on time alt");
        shift_clk = 1'b0; settle();

        // R4 load and edge together
        load_hi = 1'b1; shift_clk = 1'b1; par_in = 8'hC3; settle();
        m_def = 8'hC3; m_alt = 8'hC3;
        check_both("R4 collide default", "R4 collide alt");
        load_hi = 1'b0; settle();
        check_both("R4 collide release default", "R4 collide release alt");
        shift_clk = 1'b0; settle();

        // full readout
        do_load(8'b1011_0010);
        for (int i = 0; i < 8; i++) do_shift(1'b1);
        do_enable_pulse(1'b0);
        do_enable_pulse(1'b1);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 5);
            if (op == 0)      do_load(8'($urandom));
            else if (op == 5) do_enable_pulse(1'($urandom));
            else              do_shift(1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule